// File: doc/BRIEF.md
# Shared Counter with Per-Context Compare Timers

The block keeps one free-running counter that every processor context observes, together with a 64-bit compare value for each context. A context's timer pending flag sets once the counter has reached that context's compare value. The flag stays set until software writes that context's compare value again. Each context has its own interrupt enable, and the block drives one timer interrupt line per context. The counter width is a parameter: 32 plus a multiple of 4 bits, up to 64. The width is reported in a read-only field so that software can discover it.

Software reaches the block through a 32-bit word-addressed register port. Every access carries the number of the context that makes it. A shared window holds the configuration word, with its count-halt bit, and the two counter words. A local window holds the requesting context's compare words, its enable controls and its status. Each context also has a select register. That register points a second window, the remote window, at any context's compare and enable controls, so that one context can program another context's timer. The counter high word is not latched when the low word is read. Software that needs a consistent value reads high, low, high and retries on a mismatch.

Top module: `gtimer_cmp`

## Requirements
- R1: The counter resets to zero with counting enabled and increases by exactly one on every clock edge while the halt bit is clear.
- R2: Address 0 is the configuration word. Bit 0 is the halt bit: writing 1 freezes the counter and writing 0 resumes counting. Bits 11:8 read (counter width − 32)/4, and every other bit reads zero.
- R3: Address 1 reads counter bits 31:0 and address 2 reads bits 63:32. Bits at or above the counter width read zero. The counter wraps to zero after its all-ones value.
- R4: Writing address 1 or 2 replaces that counter word and keeps the other word. In that cycle the write takes precedence over the increment.
- R5: Each context's compare value is written and read at local addresses 4 (bits 31:0) and 5 (bits 63:32). It resets to all ones.
- R6: A context's pending flag sets one cycle after the counter, compared unsigned against the 64-bit compare value, is greater than or equal to it. The flag then holds.
- R7: Any write to a context's compare words clears its pending flag at that edge, even if a match occurs in the same cycle. The comparison is made again on the next edge.
- R8: tmr_irq[c] is the pending flag of context c ANDed with its enable. Writing a 1 in bit 0 at local address 6 sets the enable, and writing a 1 in bit 0 at address 7 clears it. Writing 0 at either address changes nothing. The enable resets to 0. Local address 9 reads the pending flag in bit 0 and the enable in bit 1.
- R9: Address 8 holds the requesting context's own target select. Addresses 12, 13, 14 and 15 act as addresses 4, 5, 6 and 7, but on the selected context, and leave the requester's own timer untouched.
- R10: Read data appears on the clock after a read strobe, with bus_rvalid high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ctx | input | CTX_W | Number of the context making the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| tmr_irq | output | NCTX | Timer interrupt, one per context |

## Verification
Two pairs of events can land on the same clock edge. A compare write can coincide with the counter already matching the new value. A counter-word write can coincide with the increment of a running counter. In the first case, the bench writes a compare value equal to the halted counter. It then expects the interrupt to be low on the cycle after the write and high one cycle later. In the second case, the bench writes the low word in the first cycle of counting and stops the counter on the next cycle. The value it reads back must be exactly one more than the value written.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;

   // word addresses of the register port
   typedef enum logic [3:0] {
      A_CFG     = 4'd0,
      A_CNT_LO  = 4'd1,
      A_CNT_HI  = 4'd2,
      A_LCMP_LO = 4'd4,
      A_LCMP_HI = 4'd5,
      A_LEN_SET = 4'd6,
      A_LEN_CLR = 4'd7,
      A_SEL     = 4'd8,
      A_LSTAT   = 4'd9,
      A_RCMP_LO = 4'd12,
      A_RCMP_HI = 4'd13,
      A_REN_SET = 4'd14,
      A_REN_CLR = 4'd15
   } reg_addr_e;

   localparam int HALT_BIT = 0;
   localparam int WFLD_LSB = 8;

   // write strobes delivered to one compare slot
   typedef struct packed {
      logic wr_lo;
      logic wr_hi;
      logic en_set;
      logic en_clr;
   } slot_wr_t;

endpackage

// File: rtl/gtimer_counter.sv
module gtimer_counter #(
   parameter int CNT_W = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic             lo_wr,
   input  logic             hi_wr,
   input  logic [31:0]      wdata,
   output logic [CNT_W-1:0] cnt_o,
   output logic             halt_o
);
   import gtimer_pkg::*;

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d, lo_val, hi_val;
   logic             halt_q;

   // word replacement differs when the counter has no upper word
   generate
      if (CNT_W > 32) begin : g_wide
         assign lo_val = {cnt_q[CNT_W-1:32], wdata};
         assign hi_val = {wdata[CNT_W-33:0], cnt_q[31:0]};
      end else begin : g_base
         assign lo_val = wdata;
         assign hi_val = cnt_q;
      end
   endgenerate

   always_comb begin
      if (lo_wr)       cnt_d = lo_val;
      else if (hi_wr)  cnt_d = hi_val;
      else if (halt_q) cnt_d = cnt_q;
      else             cnt_d = cnt_q + ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         halt_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         if (cfg_wr) halt_q <= wdata[HALT_BIT];
      end
   end

   assign cnt_o  = cnt_q;
   assign halt_o = halt_q;
endmodule

// File: rtl/gtimer_slot.sv
module gtimer_slot #(
   parameter int CNT_W = 48
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CNT_W-1:0]     cnt_i,
   input  gtimer_pkg::slot_wr_t wr_i,
   input  logic [31:0]          wdata,
   output logic [63:0]          cmp_o,
   output logic                 pend_o,
   output logic                 en_o,
   output logic                 irq_o
);
   logic [63:0] cmp_q;
   logic        pend_q, en_q, hit;

   // a narrow counter only needs the low compare bits once the upper ones are zero
   generate
      if (CNT_W < 64) begin : g_narrow
         assign hit = (cmp_q[63:CNT_W] == '0) && (cnt_i >= cmp_q[CNT_W-1:0]);
      end else begin : g_full
         assign hit = (cnt_i >= cmp_q);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q  <= '1;
         pend_q <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         if (wr_i.wr_lo) cmp_q[31:0]  <= wdata;
         if (wr_i.wr_hi) cmp_q[63:32] <= wdata;
         if (wr_i.wr_lo || wr_i.wr_hi) pend_q <= 1'b0;
         else if (hit)                 pend_q <= 1'b1;
         if (wr_i.en_set && wdata[0])      en_q <= 1'b1;
         else if (wr_i.en_clr && wdata[0]) en_q <= 1'b0;
      end
   end

   assign cmp_o  = cmp_q;
   assign pend_o = pend_q;
   assign en_o   = en_q;
   assign irq_o  = pend_q & en_q;
endmodule

// File: rtl/gtimer_decode.sv
module gtimer_decode #(
   parameter int NCTX  = 4,
   parameter int CTX_W = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               bus_wr,
   input  logic [CTX_W-1:0]                   bus_ctx,
   input  logic [3:0]                         bus_addr,
   input  logic [CTX_W-1:0]                   sel_wdata,
   output gtimer_pkg::slot_wr_t [NCTX-1:0]    slot_wr_o,
   output logic                               cfg_wr_o,
   output logic                               cnt_lo_wr_o,
   output logic                               cnt_hi_wr_o,
   output logic                               ctx_ok_o,
   output logic                               tgt_ok_o,
   output logic [CTX_W-1:0]                   sel_o,
   output logic [CTX_W-1:0]                   tgt_o
);
   import gtimer_pkg::*;

   logic [NCTX-1:0][CTX_W-1:0] sel_q;
   logic [NCTX-1:0]            loc_v, rem_v;
   logic                       ctx_ok, tgt_ok;
   logic [CTX_W-1:0]           tgt;

   always_comb begin
      ctx_ok = (32'(bus_ctx) < NCTX);
      tgt    = ctx_ok ? sel_q[bus_ctx] : '0;
      tgt_ok = ctx_ok && (32'(tgt) < NCTX);
      for (int i = 0; i < NCTX; i++) begin
         loc_v[i] = ctx_ok && (bus_ctx == CTX_W'(i));
         rem_v[i] = tgt_ok && (tgt == CTX_W'(i));
         slot_wr_o[i].wr_lo  = bus_wr && ((bus_addr == A_LCMP_LO && loc_v[i]) ||
                                          (bus_addr == A_RCMP_LO && rem_v[i]));
         slot_wr_o[i].wr_hi  = bus_wr && ((bus_addr == A_LCMP_HI && loc_v[i]) ||
                                          (bus_addr == A_RCMP_HI && rem_v[i]));
         slot_wr_o[i].en_set = bus_wr && ((bus_addr == A_LEN_SET && loc_v[i]) ||
                                          (bus_addr == A_REN_SET && rem_v[i]));
         slot_wr_o[i].en_clr = bus_wr && ((bus_addr == A_LEN_CLR && loc_v[i]) ||
                                          (bus_addr == A_REN_CLR && rem_v[i]));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else begin
         for (int i = 0; i < NCTX; i++)
            if (bus_wr && bus_addr == A_SEL && loc_v[i]) sel_q[i] <= sel_wdata;
      end
   end

   assign cfg_wr_o    = bus_wr && (bus_addr == A_CFG);
   assign cnt_lo_wr_o = bus_wr && (bus_addr == A_CNT_LO);
   assign cnt_hi_wr_o = bus_wr && (bus_addr == A_CNT_HI);
   assign ctx_ok_o    = ctx_ok;
   assign tgt_ok_o    = tgt_ok;
   assign sel_o       = ctx_ok ? sel_q[bus_ctx] : '0;
   assign tgt_o       = tgt;
endmodule

// File: rtl/gtimer_cmp.sv
module gtimer_cmp #(
   parameter int NCTX  = 4,
   parameter int CNT_W = 48,
   parameter int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CTX_W-1:0] bus_ctx,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [3:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   output logic             bus_rvalid,
   output logic [NCTX-1:0]  tmr_irq
);
   import gtimer_pkg::*;

   localparam int WFLD = (CNT_W - 32) / 4;

   // elaboration-time parameter checks
   generate
      if (CNT_W < 32 || CNT_W > 64 || (CNT_W % 4) != 0) begin : g_bad_width
         $error("gtimer_cmp: CNT_W must be 32..64 in steps of 4");
      end
      if (NCTX < 1 || NCTX > 16) begin : g_bad_ctx
         $error("gtimer_cmp: NCTX must be 1..16");
      end
      if ((1 << CTX_W) < NCTX) begin : g_bad_ctxw
         $error("gtimer_cmp: CTX_W too narrow for NCTX");
      end
   endgenerate

   slot_wr_t [NCTX-1:0]        slot_wr;
   logic                       cfg_wr, cnt_lo_wr, cnt_hi_wr, ctx_ok, tgt_ok;
   logic [CTX_W-1:0]           sel_w, tgt_w;
   logic [CNT_W-1:0]           cnt_w;
   logic                       halt_w;
   logic [NCTX-1:0][63:0]      cmp_w;
   logic [NCTX-1:0]            pend_w, en_w;
   logic [63:0]                cnt64;
   logic [31:0]                rd_d, rdata_q;
   logic                       rvalid_q;

   gtimer_decode #(.NCTX(NCTX), .CTX_W(CTX_W)) u_decode (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_ctx     (bus_ctx),
      .bus_addr    (bus_addr),
      .sel_wdata   (bus_wdata[CTX_W-1:0]),
      .slot_wr_o   (slot_wr),
      .cfg_wr_o    (cfg_wr),
      .cnt_lo_wr_o (cnt_lo_wr),
      .cnt_hi_wr_o (cnt_hi_wr),
      .ctx_ok_o    (ctx_ok),
      .tgt_ok_o    (tgt_ok),
      .sel_o       (sel_w),
      .tgt_o       (tgt_w)
   );

   gtimer_counter #(.CNT_W(CNT_W)) u_counter (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_wr (cfg_wr),
      .lo_wr  (cnt_lo_wr),
      .hi_wr  (cnt_hi_wr),
      .wdata  (bus_wdata),
      .cnt_o  (cnt_w),
      .halt_o (halt_w)
   );

   generate
      for (genvar i = 0; i < NCTX; i++) begin : g_slot
         gtimer_slot #(.CNT_W(CNT_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt_i  (cnt_w),
            .wr_i   (slot_wr[i]),
            .wdata  (bus_wdata),
            .cmp_o  (cmp_w[i]),
            .pend_o (pend_w[i]),
            .en_o   (en_w[i]),
            .irq_o  (tmr_irq[i])
         );
      end
   endgenerate

   always_comb begin
      cnt64 = 64'(cnt_w);
      rd_d  = '0;
      case (bus_addr)
         A_CFG:     rd_d = (32'(halt_w) << HALT_BIT) | (32'(WFLD) << WFLD_LSB);
         A_CNT_LO:  rd_d = cnt64[31:0];
         A_CNT_HI:  rd_d = cnt64[63:32];
         A_LCMP_LO: if (ctx_ok) rd_d = cmp_w[bus_ctx][31:0];
         A_LCMP_HI: if (ctx_ok) rd_d = cmp_w[bus_ctx][63:32];
         A_SEL:     rd_d = 32'(sel_w);
         A_LSTAT:   if (ctx_ok) rd_d = {30'd0, en_w[bus_ctx], pend_w[bus_ctx]};
         A_RCMP_LO: if (tgt_ok) rd_d = cmp_w[tgt_w][31:0];
         A_RCMP_HI: if (tgt_ok) rd_d = cmp_w[tgt_w][63:32];
         default:   rd_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         rvalid_q <= bus_rd;
         if (bus_rd) rdata_q <= rd_d;
      end
   end

   assign bus_rdata  = rdata_q;
   assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/gtimer_cmp_chk.sv
module gtimer_cmp_chk #(
   parameter int NCTX  = 4,
   parameter int CNT_W = 48,
   parameter int CTX_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CTX_W-1:0] bus_ctx,
   input logic             bus_wr,
   input logic             bus_rd,
   input logic [3:0]       bus_addr,
   input logic             wdat0,
   input logic [31:0]      bus_rdata,
   input logic             bus_rvalid,
   input logic [NCTX-1:0]  tmr_irq,
   input logic [CNT_W-1:0] cnt,
   input logic             halt
);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
   localparam logic [63:0]      HI_ONES = (64'd1 << (CNT_W - 32)) - 64'd1;
   localparam logic [31:0]      HI_MASK = ~HI_ONES[31:0];

   logic cnt_wr;
   assign cnt_wr = bus_wr && (bus_addr == 4'd1 || bus_addr == 4'd2);

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt && !cnt_wr) |=> (cnt == $past(cnt) + ONE)); // R1
   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !cnt_wr) |=> $stable(cnt)); // R2
   AST_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rvalid && $past(bus_rd && bus_addr == 4'd2)) |-> ((bus_rdata & HI_MASK) == 32'd0)); // R3
   AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_rvalid); // R10
   AST_RVALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> !bus_rvalid); // R10

   generate
      for (genvar i = 0; i < NCTX; i++) begin : g_ctx
         AST_CMP_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_ctx == CTX_W'(i) && (bus_addr == 4'd4 || bus_addr == 4'd5))
            |=> !tmr_irq[i]); // R7
         AST_EN_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_ctx == CTX_W'(i) && bus_addr == 4'd7 && wdat0)
            |=> !tmr_irq[i]); // R8
      end
   endgenerate
endmodule

bind gtimer_cmp gtimer_cmp_chk #(.NCTX(NCTX), .CNT_W(CNT_W), .CTX_W(CTX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_ctx    (bus_ctx),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_addr   (bus_addr),
   .wdat0      (bus_wdata[0]),
   .bus_rdata  (bus_rdata),
   .bus_rvalid (bus_rvalid),
   .tmr_irq    (tmr_irq),
   .cnt        (cnt_w),
   .halt       (halt_w)
);

// File: tb/gtimer_cmp_tb.sv
`timescale 1ns/1ps
module gtimer_cmp_tb;
   localparam int NCTX  = 4;
   localparam int CNT_W = 48;
   localparam int CTX_W = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CTX_W-1:0] bus_ctx = '0;
   logic             bus_wr = 1'b0;
   logic             bus_rd = 1'b0;
   logic [3:0]       bus_addr = '0;
   logic [31:0]      bus_wdata = '0;
   logic [31:0]      bus_rdata;
   logic             bus_rvalid;
   logic [NCTX-1:0]  tmr_irq;

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;   // 250 MHz

   gtimer_cmp #(.NCTX(NCTX), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_ctx(bus_ctx), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .tmr_irq(tmr_irq)
   );

   task automatic chk_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int c, input int a, input logic [31:0] d);
      bus_ctx = CTX_W'(c); bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // driver: issue a read and push the expected word to the scoreboard
   task automatic rd(input int c, input int a, input logic [31:0] exp, input string tag);
      bus_ctx = CTX_W'(c); bus_addr = 4'(a); bus_rd = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // monitor: pop and compare each returned word
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) begin
            chk_val("R10 unexpected rvalid", 32'd1, 32'd0);
         end else begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk_val(t, bus_rdata, e);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk_val("R8 irq low after reset", 32'(tmr_irq), 32'd0);
      rd(0, 0, 32'h0000_0400, "R2 cfg reset value and width field");
      rd(2, 5, 32'hFFFF_FFFF, "R5 compare high resets to ones");
      rd(3, 4, 32'hFFFF_FFFF, "R5 compare low resets to ones");
      rd(0, 9, 32'd0, "R8 status after reset");

      // halt and load
      wr(0, 0, 32'd1);
      wr(0, 1, 32'd100);
      wr(0, 2, 32'd0);
      rd(0, 1, 32'd100, "R4 counter low written");
      idle(3);
      rd(0, 1, 32'd100, "R2 counter frozen while halted");

      // run for a known number of edges: start, 9 idle, halt -> +10
      wr(0, 0, 32'd0);
      idle(9);
      wr(0, 0, 32'd1);
      rd(0, 1, 32'd110, "R1 counts one per clock");
      rd(0, 0, 32'h0000_0401, "R2 halt bit reads back");

      // upper bits and wrap
      wr(0, 2, 32'hFFFF_FFFF);
      rd(0, 2, 32'h0000_FFFF, "R3 bits above width read zero");
      wr(0, 1, 32'hFFFF_FFFE);
      wr(0, 0, 32'd0);
      idle(1);
      wr(0, 0, 32'd1);
      rd(0, 1, 32'd0, "R3 wrap low word");
      rd(0, 2, 32'd0, "R3 wrap high word");

      // counter write in the same cycle as an increment
      wr(0, 0, 32'd0);
      wr(0, 1, 32'h0000_1000);
      wr(0, 0, 32'd1);
      rd(0, 1, 32'h0000_1001, "R4 write beats increment");
      rd(0, 2, 32'd0, "R4 other word kept");

      // compare match
      wr(0, 1, 32'd100);
      wr(0, 5, 32'd0);
      wr(0, 4, 32'd105);
      rd(0, 4, 32'd105, "R5 compare low readback");
      rd(0, 5, 32'd0, "R5 compare high readback");
      wr(0, 6, 32'd1);
      chk_val("R6 below compare", 32'(tmr_irq), 32'd0);
      wr(0, 0, 32'd0);
      idle(3);
      chk_val("R6 counter 103", 32'(tmr_irq), 32'd0);
      idle(2);
      chk_val("R6 one cycle after match still low", 32'(tmr_irq), 32'd0);
      idle(1);
      chk_val("R6 pending after match", 32'(tmr_irq), 32'd1);
      wr(0, 0, 32'd1);
      idle(5);
      chk_val("R6 pending holds", 32'(tmr_irq), 32'd1);

      // enable control
      wr(0, 7, 32'd0);
      chk_val("R8 writing zero to clear has no effect", 32'(tmr_irq), 32'd1);
      wr(0, 7, 32'd1);
      chk_val("R8 enable cleared", 32'(tmr_irq), 32'd0);
      rd(0, 9, 32'd1, "R8 status pending without enable");
      wr(0, 6, 32'd1);
      chk_val("R8 enable set", 32'(tmr_irq), 32'd1);

      // compare write coinciding with a match (counter halted at 107)
      wr(0, 4, 32'd107);
      chk_val("R7 write clears despite match", 32'(tmr_irq), 32'd0);
      idle(1);
      chk_val("R7 re-evaluated next cycle", 32'(tmr_irq), 32'd1);
      wr(0, 4, 32'd200);
      chk_val("R7 cleared by write", 32'(tmr_irq), 32'd0);
      idle(2);
      chk_val("R7 stays low above counter", 32'(tmr_irq), 32'd0);

      // remote window
      wr(0, 8, 32'd2);
      rd(0, 8, 32'd2, "R9 select readback");
      wr(0, 13, 32'd0);
      wr(0, 12, 32'd50);
      rd(2, 4, 32'd50, "R9 remote write reaches target");
      rd(0, 4, 32'd200, "R9 requester compare untouched");
      rd(0, 12, 32'd50, "R9 remote read");
      wr(0, 14, 32'd1);
      idle(1);
      chk_val("R9 remote enable drives target irq", 32'(tmr_irq), 32'h4);
      rd(2, 9, 32'd3, "R9 target status");
      wr(0, 15, 32'd1);
      chk_val("R9 remote clear", 32'(tmr_irq), 32'd0);

      // read valid timing
      chk_val("R10 rvalid low when idle", 32'(bus_rvalid), 32'd0);
      idle(3);
      chk_val("R10 scoreboard drained", 32'(exp_q.size()), 32'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule